// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a time-of-day value split into a seconds field and a nanoseconds field. While running, it adds a programmable nanosecond increment to the time. The nanosecond field rolls over either at one billion (decimal mode) or at the full binary range of the field (binary mode). Each rollover carries one into the seconds field and raises a single-cycle tick.

The increment can be applied on every clock (coarse stepping). It can also be applied only on the clocks where a fractional-rate accumulator overflows (fine stepping), which lets software trim the effective rate. A simple register-style write port configures the block. The same port can replace the time with an absolute value, clear it, or apply an offset. The offset is added to or subtracted from the running time in one step, and the block handles the carry and borrow between the two fields.

Time synchronisation firmware uses the block as the local clock. The firmware loads the time once, and from then on steers it with offsets and rate changes. It reads the live fields directly from the outputs.

Top module: `tod_counter`

Write-port map (the address is `wr_addr`, the value is `wr_data`):

| Address | Content |
|---|---|
| 0 | Control. Bit 0 is run. Bit 1 is fine stepping (0 = coarse). Bit 2 is binary rollover (0 = decimal). |
| 1 | Nanosecond increment. |
| 2 | Fine-rate addend. |
| 3 | Staged seconds, used by load and by offsets. |
| 4 | Staged nanoseconds, used by load and by offsets. |
| 5 | Command. Bit 1 clears the time. Bit 0 loads the staged value. Bit 2 applies the staged value as an offset, and bit 3 set makes that offset a subtraction. Priority is clear, then load, then offset. |

## Requirements
- R1: After reset, the seconds field, the nanoseconds field and the tick are all 0. The block is stopped, in coarse stepping, in decimal rollover, with a zero increment and a zero addend.
- R2: With run set and coarse stepping, each clock adds the increment to the nanoseconds field. The sum appears on the outputs one clock after the edge.
- R3: In decimal mode, a sum that reaches 1,000,000,000 has that value subtracted from it, and the seconds field goes up by one.
- R4: In binary mode, the nanoseconds field wraps modulo 2^NS_W, and the seconds field goes up by one on each wrap. Values of one billion and above are legal in this mode.
- R5: In fine stepping, the addend is added to an ACC_W-bit accumulator on each running clock. The increment is applied only on clocks where that addition carries out. With an addend of 2^30, the increment lands on every fourth clock.
- R6: With run clear, the time holds its value and is not cleared. After run is set again, counting continues from the held value.
- R7: A load command replaces the time with the staged seconds and staged nanoseconds.
- R8: A clear command sets both fields to 0. It takes priority over the other command bits.
- R9: An add offset adds the staged nanoseconds and staged seconds to the time. If the nanoseconds sum reaches the rollover base, the base is removed and one more second is added.
- R10: A subtract offset removes the staged values from the time. If the staged nanoseconds exceed the current nanoseconds, the rollover base is added and one more second is taken.
- R11: A command takes effect in the clock it is written, and no increment is applied in that clock.
- R12: The tick is high for exactly the one cycle in which the seconds field shows a value advanced by normal counting. It stays low when the seconds field changes through a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | Write address (see map above) |
| wr_data | input | DATA_W | Write value |
| sec_o | output | SEC_W | Live seconds field |
| ns_o | output | NS_W | Live nanoseconds field |
| sec_tick_o | output | 1 | One-cycle pulse on a counted second advance |

## Verification
Coarse counting is run with a small increment from a value just below one billion. This separates a correct decimal rollover from a wrap at the binary limit. The same increment in binary mode near 2^32 checks the opposite case.

Offsets are applied with nanosecond parts chosen to force a carry on add and a borrow on subtract, in both rollover modes. These show whether the cross-field adjustment is done and whether the increment is wrongly added in the command cycle.

Fine stepping with a quarter-scale addend must produce exactly one increment every fourth clock. Stop and restart sequences show the time is held rather than reset.

// File: rtl/tod_pkg.sv
// Package: shared address map, control and command types for the
// time-of-day counter. Assumes a 3-bit register address space.
package tod_pkg;

    localparam int unsigned ADDR_W      = 3;
    localparam int unsigned NS_DEC_WRAP = 1000000000;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL    = 3'd0,
        REG_STEP    = 3'd1,
        REG_ADDEND  = 3'd2,
        REG_OFF_SEC = 3'd3,
        REG_OFF_NS  = 3'd4,
        REG_CMD     = 3'd5
    } tod_reg_e;

    // Control register bits: run = bit 0, fine = bit 1, binary = bit 2
    typedef struct packed {
        logic binary;
        logic fine;
        logic run;
    } tod_ctrl_t;

    // Decoded command strobe; valid only in the write cycle
    typedef struct packed {
        logic any;
        logic zero;
        logic load;
        logic adjust;
        logic subtract;
    } tod_cmd_t;

endpackage

// File: rtl/tod_regs.sv
// Module: tod_regs
// Holds the control, increment, addend and staged time registers written
// through the simple write port, and decodes command writes into a
// single-cycle strobe. Assumes NS_W, SEC_W and ACC_W are no wider than DATA_W.
module tod_regs
    import tod_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NS_W   = 32,
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned ACC_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output tod_ctrl_t             ctrl_o,
    output logic [NS_W-1:0]       step_o,
    output logic [ACC_W-1:0]      addend_o,
    output logic [SEC_W-1:0]      off_sec_o,
    output logic [NS_W-1:0]       off_ns_o,
    output tod_cmd_t              cmd_o
);

    // Register writes; commands are not stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o    <= '0;
            step_o    <= '0;
            addend_o  <= '0;
            off_sec_o <= '0;
            off_ns_o  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CTRL:    ctrl_o    <= tod_ctrl_t'(wr_data[2:0]);
                REG_STEP:    step_o    <= wr_data[NS_W-1:0];
                REG_ADDEND:  addend_o  <= wr_data[ACC_W-1:0];
                REG_OFF_SEC: off_sec_o <= wr_data[SEC_W-1:0];
                REG_OFF_NS:  off_ns_o  <= wr_data[NS_W-1:0];
                default: ;
            endcase
        end
    end

    // Command decode with priority clear > load > offset
    always_comb begin
        cmd_o          = '0;
        cmd_o.any      = wr_en && (wr_addr == REG_CMD);
        cmd_o.zero     = cmd_o.any && wr_data[1];
        cmd_o.load     = cmd_o.any && wr_data[0] && !wr_data[1];
        cmd_o.adjust   = cmd_o.any && wr_data[2] && !wr_data[1] && !wr_data[0];
        cmd_o.subtract = wr_data[3];
    end

endmodule

// File: rtl/tod_step_gen.sv
// Module: tod_step_gen
// Decides on which clocks the nanosecond increment is applied. In coarse
// mode that is every advancing clock; in fine mode only clocks where the
// fractional accumulator carries out. The accumulator moves only while
// advancing in fine mode.
module tod_step_gen #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             fine,
    input  logic [ACC_W-1:0] addend,
    output logic             fire
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_sum;

    // Next accumulator value with carry
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, addend};
        fire    = advance && (fine ? acc_sum[ACC_W] : 1'b1);
    end

    // Accumulator state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (advance && fine) begin
            acc_q <= acc_sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/tod_ns_arith.sv
// Module: tod_ns_arith
// Combinational nanosecond add or subtract with rollover base selected by
// mode (one billion or 2^NS_W). Reports carry on add or borrow on subtract.
// Assumes operands are below the active base.
module tod_ns_arith
    import tod_pkg::*;
#(
    parameter int unsigned NS_W = 32
) (
    input  logic [NS_W-1:0] a_i,
    input  logic [NS_W-1:0] b_i,
    input  logic            sub_i,
    input  logic            binary_i,
    output logic [NS_W-1:0] res_o,
    output logic            cross_o
);

    localparam logic [NS_W:0] DEC_BASE = (NS_W+1)'(NS_DEC_WRAP);

    logic [NS_W:0] raw;
    logic [NS_W:0] fixed;

    // Raw sum or difference, then base correction
    always_comb begin
        if (sub_i) begin
            raw     = {1'b0, a_i} - {1'b0, b_i};
            cross_o = raw[NS_W];
            fixed   = (cross_o && !binary_i) ? raw + DEC_BASE : raw;
        end else begin
            raw     = {1'b0, a_i} + {1'b0, b_i};
            cross_o = binary_i ? raw[NS_W] : (raw >= DEC_BASE);
            fixed   = (cross_o && !binary_i) ? raw - DEC_BASE : raw;
        end
        res_o = fixed[NS_W-1:0];
    end

endmodule

// File: rtl/tod_counter.sv
// Module: tod_counter (top)
// Seconds/nanoseconds time-of-day counter with programmable increment,
// coarse or fine stepping, decimal or binary rollover, absolute load,
// clear and signed offset correction. A command in a cycle replaces the
// normal increment for that cycle.
module tod_counter
    import tod_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NS_W   = 32,
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SEC_W-1:0]  sec_o,
    output logic [NS_W-1:0]   ns_o,
    output logic              sec_tick_o
);

    tod_ctrl_t         ctrl;
    tod_cmd_t          cmd;
    logic [NS_W-1:0]   step;
    logic [ACC_W-1:0]  addend;
    logic [SEC_W-1:0]  off_sec;
    logic [NS_W-1:0]   off_ns;
    logic              run_w;
    logic              binary_w;
    logic              advance;
    logic              fire;
    logic [NS_W-1:0]   step_ns;
    logic              step_cross;
    logic [NS_W-1:0]   corr_ns;
    logic              corr_cross;
    logic [SEC_W-1:0]  corr_sec;
    logic [SEC_W-1:0]  sec_q;
    logic [NS_W-1:0]   ns_q;
    logic              tick_q;

    tod_regs #(
        .DATA_W(DATA_W), .NS_W(NS_W), .SEC_W(SEC_W), .ACC_W(ACC_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ctrl_o    (ctrl),
        .step_o    (step),
        .addend_o  (addend),
        .off_sec_o (off_sec),
        .off_ns_o  (off_ns),
        .cmd_o     (cmd)
    );

    assign run_w    = ctrl.run;
    assign binary_w = ctrl.binary;
    assign advance  = run_w && !cmd.any;

    tod_step_gen #(.ACC_W(ACC_W)) u_step_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .fine    (ctrl.fine),
        .addend  (addend),
        .fire    (fire)
    );

    tod_ns_arith #(.NS_W(NS_W)) u_step_add (
        .a_i      (ns_q),
        .b_i      (step),
        .sub_i    (1'b0),
        .binary_i (binary_w),
        .res_o    (step_ns),
        .cross_o  (step_cross)
    );

    tod_ns_arith #(.NS_W(NS_W)) u_corr (
        .a_i      (ns_q),
        .b_i      (off_ns),
        .sub_i    (cmd.subtract),
        .binary_i (binary_w),
        .res_o    (corr_ns),
        .cross_o  (corr_cross)
    );

    // Seconds after an offset, including carry or borrow from nanoseconds
    always_comb begin
        if (cmd.subtract) begin
            corr_sec = sec_q - off_sec - SEC_W'(corr_cross);
        end else begin
            corr_sec = sec_q + off_sec + SEC_W'(corr_cross);
        end
    end

    // Time state and second tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            ns_q   <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (cmd.zero) begin
                sec_q <= '0;
                ns_q  <= '0;
            end else if (cmd.load) begin
                sec_q <= off_sec;
                ns_q  <= off_ns;
            end else if (cmd.adjust) begin
                sec_q <= corr_sec;
                ns_q  <= corr_ns;
            end else if (fire) begin
                ns_q   <= step_ns;
                sec_q  <= sec_q + SEC_W'(step_cross);
                tick_q <= step_cross;
            end
        end
    end

    assign sec_o      = sec_q;
    assign ns_o       = ns_q;
    assign sec_tick_o = tick_q;

endmodule

// File: rtl/tod_counter_chk.sv
// Module: tod_counter_chk
// Property checker attached to tod_counter by bind. Assumes increments
// below one billion in decimal mode.
module tod_counter_chk
    import tod_pkg::*;
#(
    parameter int unsigned NS_W  = 32,
    parameter int unsigned SEC_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_zero,
    input logic [SEC_W-1:0]  sec_o,
    input logic [NS_W-1:0]   ns_o,
    input logic              sec_tick_o,
    input logic              run,
    input logic              binary
);

    localparam logic [NS_W:0] DEC = (NS_W+1)'(NS_DEC_WRAP);

    logic cmd_wr;
    assign cmd_wr = wr_en && (wr_addr == REG_CMD);

    // R6: stopped and no command keeps time unchanged
    a_r6_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cmd_wr) |=> ($stable(sec_o) && $stable(ns_o)));

    // R12: a tick only shows alongside a one-second advance
    a_r12_tick_advances: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick_o |-> (sec_o == $past(sec_o) + SEC_W'(1)));

    // R11: a command cycle never yields a tick
    a_r11_no_tick_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !sec_tick_o);

    // R8: clear command empties both fields
    a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wr_zero) |=> (sec_o == '0 && ns_o == '0));

    // R3: decimal counting keeps nanoseconds below one billion
    a_r3_decimal_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!binary && !cmd_wr && ({1'b0, ns_o} < DEC)) |=> ({1'b0, ns_o} < DEC));

endmodule

bind tod_counter tod_counter_chk #(.NS_W(NS_W), .SEC_W(SEC_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_zero    (wr_data[1]),
    .sec_o      (sec_o),
    .ns_o       (ns_o),
    .sec_tick_o (sec_tick_o),
    .run        (run_w),
    .binary     (binary_w)
);

// File: tb/tod_counter_tb_top.sv
// Scoreboard bench: the driver applies one write-port cycle at a time,
// predicts the outputs after the next edge and queues them; a monitor
// compares one queued item after each rising edge.
module tod_counter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam longint DEC = 1000000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] sec_o;
    logic [31:0] ns_o;
    logic        sec_tick_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] sec;
        logic [31:0] ns;
        logic        tick;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference state
    logic [31:0] m_sec = 0, m_ns = 0, m_step = 0, m_add = 0, m_acc = 0;
    logic [31:0] m_osec = 0, m_ons = 0;
    bit m_run = 0, m_fine = 0, m_bin = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_counter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .sec_o      (sec_o),
        .ns_o       (ns_o),
        .sec_tick_o (sec_tick_o)
    );

    task automatic cyc(input bit we, input logic [2:0] a, input logic [31:0] d, input string tag);
        longint base;
        longint t;
        bit fire;
        exp_t e;
        logic tick;
        wr_en   = we;
        wr_addr = a;
        wr_data = d;
        base = m_bin ? 64'h1_0000_0000 : DEC;
        tick = 1'b0;
        if (we && a == 3'd5) begin
            if (d[1]) begin
                m_sec = 0; m_ns = 0;
            end else if (d[0]) begin
                m_sec = m_osec; m_ns = m_ons;
            end else if (d[2]) begin
                if (d[3]) begin
                    t = longint'(m_ns) - longint'(m_ons);
                    m_sec = m_sec - m_osec;
                    if (t < 0) begin t = t + base; m_sec = m_sec - 1; end
                end else begin
                    t = longint'(m_ns) + longint'(m_ons);
                    m_sec = m_sec + m_osec;
                    if (t >= base) begin t = t - base; m_sec = m_sec + 1; end
                end
                m_ns = t[31:0];
            end
        end else if (m_run) begin
            fire = 1'b1;
            if (m_fine) begin
                t = longint'(m_acc) + longint'(m_add);
                fire = (t >= 64'h1_0000_0000);
                m_acc = t[31:0];
            end
            if (fire) begin
                t = longint'(m_ns) + longint'(m_step);
                if (t >= base) begin t = t - base; m_sec = m_sec + 1; tick = 1'b1; end
                m_ns = t[31:0];
            end
        end
        if (we) begin
            case (a)
                3'd0: begin m_run = d[0]; m_fine = d[1]; m_bin = d[2]; end
                3'd1: m_step = d;
                3'd2: m_add  = d;
                3'd3: m_osec = d;
                3'd4: m_ons  = d;
                default: ;
            endcase
        end
        e.sec = m_sec; e.ns = m_ns; e.tick = tick; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 32'd0, tag);
    endtask

    // Monitor: compare one prediction after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (sec_o !== e.sec || ns_o !== e.ns || sec_tick_o !== e.tick) begin
                    errors++;
                    $display("FAIL %s: actual sec=%0d ns=%0d tick=%0b expected sec=%0d ns=%0d tick=%0b",
                             e.tag, sec_o, ns_o, sec_tick_o, e.sec, e.ns, e.tick);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (sec_o !== 0 || ns_o !== 0 || sec_tick_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual sec=%0d ns=%0d tick=%0b expected 0 0 0", sec_o, ns_o, sec_tick_o);
        end
        idle(2, "R1 stopped after reset");
        // R2 coarse counting
        cyc(1, 3'd1, 32'd10, "R2");
        cyc(1, 3'd0, 32'd1, "R2");
        idle(4, "R2 coarse step");
        // R7 load, R3 decimal wrap, R12 tick
        cyc(1, 3'd3, 32'd5, "R7");
        cyc(1, 3'd4, 32'd999_999_990, "R7");
        cyc(1, 3'd5, 32'h1, "R7 load");
        idle(1, "R3 decimal wrap");
        idle(2, "R12 tick single cycle");
        // R9 add with carry, R11 no step in command cycle
        cyc(1, 3'd3, 32'd2, "R9");
        cyc(1, 3'd4, 32'd999_999_995, "R9");
        cyc(1, 3'd5, 32'h4, "R9 R11 R12 add carry");
        idle(2, "R9");
        // R10 subtract with borrow
        cyc(1, 3'd3, 32'd1, "R10");
        cyc(1, 3'd4, 32'd999_999_999, "R10");
        cyc(1, 3'd5, 32'hC, "R10 R11 sub borrow");
        idle(1, "R10");
        // R6 stop and resume
        cyc(1, 3'd0, 32'd0, "R6");
        idle(3, "R6 held");
        cyc(1, 3'd0, 32'd1, "R6");
        idle(2, "R6 resumed");
        // R8 clear with other bits also set
        cyc(1, 3'd5, 32'h7, "R8 clear priority");
        idle(1, "R8");
        // R4 binary rollover
        cyc(1, 3'd0, 32'd5, "R4");
        cyc(1, 3'd3, 32'd0, "R4");
        cyc(1, 3'd4, 32'hFFFF_FFD0, "R4");
        cyc(1, 3'd5, 32'h1, "R4 load high");
        idle(6, "R4 binary wrap");
        cyc(1, 3'd4, 32'h40, "R10");
        cyc(1, 3'd5, 32'hC, "R10 binary borrow");
        idle(1, "R10");
        // R5 fine stepping, one increment per four clocks
        cyc(1, 3'd0, 32'd1, "R5");
        cyc(1, 3'd3, 32'd9, "R5");
        cyc(1, 3'd4, 32'd0, "R5");
        cyc(1, 3'd5, 32'h1, "R5 load");
        cyc(1, 3'd2, 32'h4000_0000, "R5");
        cyc(1, 3'd0, 32'd3, "R5");
        idle(12, "R5 fine step");
        cyc(1, 3'd4, 32'd999_999_995, "R5");
        cyc(1, 3'd5, 32'h1, "R5 load");
        idle(8, "R5 R3 fine wrap");
        cyc(1, 3'd5, 32'h2, "R8 clear");
        idle(2, "R8");
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule